// File: doc/BRIEF.md
# Virtual Address Translation Checker

This block sits in a 32-bit processor memory pipeline. It takes one memory request at a time and decides where the request goes. Each request carries a virtual address, an access kind (read, write or prefetch), a privilege flag, and three control bits: translation enable, single-virtual mode and user store-queue lock. The result is one of two things. It can be a physical address with a region tag that names external memory, the control region or the store-queue window. It can instead be an exception code. The result is registered, so it appears one cycle after the request.

A small fully associative TLB is held in internal registers. Software loads one entry per cycle through a write port. Each entry holds:
- a virtual page number;
- an ASID;
- a physical page number;
- a two-bit page-size code;
- valid, user, writable and dirty flags.

All entries are compared in parallel. The unit detects a miss, a single hit or a multiple hit. It applies the permission and dirty rules for the access kind and builds the physical address from the page size.

Each request is sorted into one of five routes:
- CTRL_PASS is taken for a privileged access at 0xE0000000 or above.
- EXT_PASS is taken for a privileged access from 0x80000000 to 0xBFFFFFFF. It is also taken for any remaining address while translation is off.
- SQ_WIN is taken for a user access inside the store-queue window while the lock is clear.
- ADDR_ERR is taken for any other user access with bit 31 set.
- LOOKUP is taken for all other addresses while translation is on.

The result stage moves from a route to a response in the same cycle. It holds no other state.

Top module: `vat_unit`

## Requirements
- R1: After reset, rsp_valid is 0, rsp_region is 0 and rsp_exc is 0. For a request sampled at a clock edge, rsp_valid is 1 after that edge, and rsp_valid is 0 after any edge with no request.
- R2: For a privileged access at or above 0xE0000000, rsp_region is 1 (control), rsp_exc is 0 and rsp_paddr equals the virtual address.
- R3: For a privileged access from 0x80000000 to 0xBFFFFFFF, rsp_region is 0 (external), rsp_exc is 0 and rsp_paddr is the virtual address with bits 31:29 cleared.
- R4: A user access with bit 31 set goes to region 2 (store queue) with rsp_paddr equal to the virtual address only when the address is from 0xE0000000 to 0xE3FFFFFF and ctl_sq_lock is 0. Any other such access raises code 1 for a read or prefetch and code 2 for a write.
- R5: With ctl_xlate_en at 0, every address not handled by R2 to R4 goes to region 0 with bits 31:29 cleared. This includes a privileged access from 0xC0000000 to 0xDFFFFFFF. With ctl_xlate_en at 1, those addresses go through the TLB.
- R6: The lookup compares the entry ASID with cur_asid when ctl_single_vs is 0 or the access is from user mode. Otherwise the ASID is ignored.
- R7: When no entry matches, a read raises code 3 and a write raises code 4. When more than one entry matches, any access kind, prefetch included, raises code 5.
- R8: A user read hitting an entry whose user flag is clear raises code 6.
- R9: A privileged write needs the writable flag, and a user write needs both the user and writable flags. A failure raises code 7, and this check is made before the dirty check.
- R10: A permitted write to an entry whose dirty flag is clear raises code 8.
- R11: The physical address is (PPN AND mask) OR (VA AND NOT mask). Size codes 0, 1, 2 and 3 select 1 KB, 4 KB, 64 KB and 1 MB pages.
- R12: A physical result above 0x1C000000 is ORed with 0xE0000000 and goes to region 1. A result of exactly 0x1C000000 or less goes to region 0.
- R13: A prefetch that misses, or that breaks the user-flag rule, reports region 3 (unmapped) with code 0.
- R14: An entry written at one edge takes part in lookups from the next request on. An entry with its valid flag clear never matches.

On any exception, rsp_region is 3 and rsp_paddr holds the virtual address. req_kind 0 means read, 1 means write and 2 means prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 prefetch |
| req_priv | input | 1 | 1 = privileged access |
| ctl_xlate_en | input | 1 | Address translation enable |
| ctl_single_vs | input | 1 | Single-virtual mode (ASID ignored when privileged) |
| ctl_sq_lock | input | 1 | 1 = store-queue window closed to user mode |
| cur_asid | input | ASID_W | Current address-space identifier |
| tlb_we | input | 1 | TLB entry write strobe |
| tlb_idx | input | log2(N_ENTRIES) | Entry index to write |
| tlb_vpn | input | 22 | Virtual page number (VA bits 31:10) |
| tlb_asid | input | ASID_W | Entry ASID |
| tlb_ppn | input | 19 | Physical page number (PA bits 28:10) |
| tlb_size | input | 2 | Page-size code |
| tlb_valid | input | 1 | Entry valid flag |
| tlb_user | input | 1 | Entry user-access flag |
| tlb_wr | input | 1 | Entry writable flag |
| tlb_dirty | input | 1 | Entry dirty flag |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address, or virtual address on fault or unmapped |
| rsp_region | output | 2 | 0 external, 1 control, 2 store queue, 3 unmapped |
| rsp_exc | output | 4 | Exception code, 0 none |

## Verification
The hardest outcomes to reach are those that need particular TLB contents:
- a multiple hit, both for a normal access and for a prefetch that must still fault;
- a write that breaks the permission rule and also targets a clean page, so both checks apply at once;
- a translated result that sits exactly at the 0x1C000000 remap boundary or just above it.

The stimulus first loads crafted entries through the write port. These include two overlapping entries, a privileged-only clean page, a read-only user page, pages of all four sizes, and a page placed so that offset zero lands exactly on the boundary. Directed requests then hit each of these entries. A long run of mixed requests follows, with the access kind, privilege, control bits and ASID varied against a behavioural model.

// File: rtl/vat_pkg.sv
package vat_pkg;
    localparam int VPN_W = 22;
    localparam int PPN_W = 19;
    localparam int OFS_W = 10;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_PREF  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        RG_EXT   = 2'd0,
        RG_CTRL  = 2'd1,
        RG_SQ    = 2'd2,
        RG_UNMAP = 2'd3
    } region_e;

    typedef enum logic [3:0] {
        EX_NONE    = 4'd0,
        EX_ADDR_RD = 4'd1,
        EX_ADDR_WR = 4'd2,
        EX_MISS_RD = 4'd3,
        EX_MISS_WR = 4'd4,
        EX_MULTI   = 4'd5,
        EX_PROT_RD = 4'd6,
        EX_PROT_WR = 4'd7,
        EX_INIT_WR = 4'd8
    } exc_e;

    typedef enum logic [2:0] {
        RT_CTRL_PASS,
        RT_EXT_PASS,
        RT_SQ_WIN,
        RT_ADDR_ERR,
        RT_LOOKUP
    } route_e;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        logic [1:0]       size;
        logic             valid;
        logic             user;
        logic             wr;
        logic             dirty;
    } tlb_ent_t;

    // Page-number bits that take part in a compare, per size code
    function automatic logic [VPN_W-1:0] vpn_keep(input logic [1:0] sz);
        case (sz)
            2'd0:    return {VPN_W{1'b1}};
            2'd1:    return {{(VPN_W-2){1'b1}}, 2'b00};
            2'd2:    return {{(VPN_W-6){1'b1}}, 6'b0};
            default: return {{(VPN_W-10){1'b1}}, 10'b0};
        endcase
    endfunction
endpackage

// File: rtl/vat_tlb_array.sv
module vat_tlb_array
    import vat_pkg::*;
#(
    parameter  int N_ENTRIES = 64,
    parameter  int ASID_W    = 8,
    localparam int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  tlb_ent_t                          wr_ent,
    input  logic [ASID_W-1:0]                 wr_asid,
    input  logic [VPN_W-1:0]                  lk_vpn,
    input  logic [ASID_W-1:0]                 lk_asid,
    input  logic                              lk_asid_cmp,
    output logic [N_ENTRIES-1:0]              hit_o,
    output logic [N_ENTRIES-1:0][PPN_W-1:0]   ppn_o,
    output logic [N_ENTRIES-1:0][1:0]         size_o,
    output logic [N_ENTRIES-1:0]              user_o,
    output logic [N_ENTRIES-1:0]              wr_o,
    output logic [N_ENTRIES-1:0]              dirty_o
);
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
        tlb_ent_t          ent_q;
        logic [ASID_W-1:0] asid_q;
        logic [VPN_W-1:0]  keep;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q  <= '0;
                asid_q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                ent_q  <= wr_ent;
                asid_q <= wr_asid;
            end
        end

        assign keep     = vpn_keep(ent_q.size);
        assign hit_o[g] = ent_q.valid
                        && (((ent_q.vpn ^ lk_vpn) & keep) == '0)
                        && (!lk_asid_cmp || asid_q == lk_asid);
        assign ppn_o[g]   = ent_q.ppn;
        assign size_o[g]  = ent_q.size;
        assign user_o[g]  = ent_q.user;
        assign wr_o[g]    = ent_q.wr;
        assign dirty_o[g] = ent_q.dirty;
    end
endmodule

// File: rtl/vat_hit_pick.sv
module vat_hit_pick
    import vat_pkg::*;
#(
    parameter  int N_ENTRIES = 64,
    localparam int CNT_W     = $clog2(N_ENTRIES) + 1
) (
    input  logic [N_ENTRIES-1:0]            hit_i,
    input  logic [N_ENTRIES-1:0][PPN_W-1:0] ppn_i,
    input  logic [N_ENTRIES-1:0][1:0]       size_i,
    input  logic [N_ENTRIES-1:0]            user_i,
    input  logic [N_ENTRIES-1:0]            wr_i,
    input  logic [N_ENTRIES-1:0]            dirty_i,
    output logic                            any_o,
    output logic                            multi_o,
    output logic [PPN_W-1:0]                sel_ppn,
    output logic [1:0]                      sel_size,
    output logic                            sel_user,
    output logic                            sel_wr,
    output logic                            sel_dirty
);
    logic [CNT_W-1:0] cnt;

    // OR-merge of hit entries: exact when one hit, and a multi-hit faults anyway
    always_comb begin
        cnt       = '0;
        sel_ppn   = '0;
        sel_size  = '0;
        sel_user  = 1'b0;
        sel_wr    = 1'b0;
        sel_dirty = 1'b0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (hit_i[i]) begin
                cnt       = cnt + CNT_W'(1);
                sel_ppn   = sel_ppn | ppn_i[i];
                sel_size  = sel_size | size_i[i];
                sel_user  = sel_user | user_i[i];
                sel_wr    = sel_wr | wr_i[i];
                sel_dirty = sel_dirty | dirty_i[i];
            end
        end
    end

    assign any_o   = (cnt != '0);
    assign multi_o = (cnt > CNT_W'(1));
endmodule

// File: rtl/vat_decide.sv
module vat_decide
    import vat_pkg::*;
(
    input  logic [31:0]      va,
    input  acc_e             kind,
    input  logic             priv,
    input  logic             xlate_en,
    input  logic             single_vs,
    input  logic             sq_lock,
    input  logic             any_hit,
    input  logic             multi_hit,
    input  logic [PPN_W-1:0] sel_ppn,
    input  logic [1:0]       sel_size,
    input  logic             sel_user,
    input  logic             sel_wr,
    input  logic             sel_dirty,
    output logic             asid_cmp,
    output region_e          region,
    output exc_e             exc,
    output logic [31:0]      paddr
);
    route_e      route;
    logic        is_wr;
    logic        is_pf;
    logic        wr_ok;
    logic [31:0] pmask;
    logic [31:0] pma;

    assign is_wr    = (kind == ACC_WRITE);
    assign is_pf    = (kind == ACC_PREF);
    assign asid_cmp = !single_vs || !priv;
    assign wr_ok    = priv ? sel_wr : (sel_user && sel_wr);
    assign pmask    = {vpn_keep(sel_size), {OFS_W{1'b0}}};
    assign pma      = ({3'b000, sel_ppn, {OFS_W{1'b0}}} & pmask) | (va & ~pmask);

    // Route selection
    always_comb begin
        if (va[31] && priv && va[31:29] == 3'b111) begin
            route = RT_CTRL_PASS;
        end else if (va[31] && priv && va[30] == 1'b0) begin
            route = RT_EXT_PASS;
        end else if (va[31] && !priv) begin
            route = (va[31:26] == 6'b111000 && !sq_lock) ? RT_SQ_WIN : RT_ADDR_ERR;
        end else begin
            route = xlate_en ? RT_LOOKUP : RT_EXT_PASS;
        end
    end

    // Response per route
    always_comb begin
        region = RG_UNMAP;
        exc    = EX_NONE;
        paddr  = va;
        unique case (route)
            RT_CTRL_PASS: region = RG_CTRL;
            RT_EXT_PASS: begin
                region = RG_EXT;
                paddr  = {3'b000, va[28:0]};
            end
            RT_SQ_WIN:   region = RG_SQ;
            RT_ADDR_ERR: exc = is_wr ? EX_ADDR_WR : EX_ADDR_RD;
            RT_LOOKUP: begin
                if (multi_hit) begin
                    exc = EX_MULTI;
                end else if (!any_hit) begin
                    if (!is_pf) exc = is_wr ? EX_MISS_WR : EX_MISS_RD;
                end else if (is_wr && !wr_ok) begin
                    exc = EX_PROT_WR;
                end else if (is_wr && !sel_dirty) begin
                    exc = EX_INIT_WR;
                end else if (!is_wr && !priv && !sel_user) begin
                    if (!is_pf) exc = EX_PROT_RD;
                end else if (pma > 32'h1C00_0000) begin
                    region = RG_CTRL;
                    paddr  = pma | 32'hE000_0000;
                end else begin
                    region = RG_EXT;
                    paddr  = pma;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vat_unit.sv
module vat_unit
    import vat_pkg::*;
#(
    parameter  int N_ENTRIES = 64,
    parameter  int ASID_W    = 8,
    localparam int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_va,
    input  logic [1:0]        req_kind,
    input  logic              req_priv,
    input  logic              ctl_xlate_en,
    input  logic              ctl_single_vs,
    input  logic              ctl_sq_lock,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              tlb_we,
    input  logic [IDX_W-1:0]  tlb_idx,
    input  logic [21:0]       tlb_vpn,
    input  logic [ASID_W-1:0] tlb_asid,
    input  logic [18:0]       tlb_ppn,
    input  logic [1:0]        tlb_size,
    input  logic              tlb_valid,
    input  logic              tlb_user,
    input  logic              tlb_wr,
    input  logic              tlb_dirty,
    output logic              rsp_valid,
    output logic [31:0]       rsp_paddr,
    output logic [1:0]        rsp_region,
    output logic [3:0]        rsp_exc
);
    tlb_ent_t                        wr_ent;
    logic                            asid_cmp;
    logic [N_ENTRIES-1:0]            hit;
    logic [N_ENTRIES-1:0][PPN_W-1:0] ppn_v;
    logic [N_ENTRIES-1:0][1:0]       size_v;
    logic [N_ENTRIES-1:0]            user_v, wr_v, dirty_v;
    logic                            any_hit, multi_hit;
    logic [PPN_W-1:0]                sel_ppn;
    logic [1:0]                      sel_size;
    logic                            sel_user, sel_wr, sel_dirty;
    region_e                         nxt_region;
    exc_e                            nxt_exc;
    logic [31:0]                     nxt_paddr;

    assign wr_ent = '{vpn: tlb_vpn, ppn: tlb_ppn, size: tlb_size, valid: tlb_valid,
                      user: tlb_user, wr: tlb_wr, dirty: tlb_dirty};

    vat_tlb_array #(.N_ENTRIES(N_ENTRIES), .ASID_W(ASID_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tlb_we), .wr_idx(tlb_idx), .wr_ent(wr_ent), .wr_asid(tlb_asid),
        .lk_vpn(req_va[31:OFS_W]), .lk_asid(cur_asid), .lk_asid_cmp(asid_cmp),
        .hit_o(hit), .ppn_o(ppn_v), .size_o(size_v),
        .user_o(user_v), .wr_o(wr_v), .dirty_o(dirty_v)
    );

    vat_hit_pick #(.N_ENTRIES(N_ENTRIES)) u_pick (
        .hit_i(hit), .ppn_i(ppn_v), .size_i(size_v),
        .user_i(user_v), .wr_i(wr_v), .dirty_i(dirty_v),
        .any_o(any_hit), .multi_o(multi_hit),
        .sel_ppn(sel_ppn), .sel_size(sel_size),
        .sel_user(sel_user), .sel_wr(sel_wr), .sel_dirty(sel_dirty)
    );

    vat_decide u_decide (
        .va(req_va), .kind(acc_e'(req_kind)), .priv(req_priv),
        .xlate_en(ctl_xlate_en), .single_vs(ctl_single_vs), .sq_lock(ctl_sq_lock),
        .any_hit(any_hit), .multi_hit(multi_hit),
        .sel_ppn(sel_ppn), .sel_size(sel_size),
        .sel_user(sel_user), .sel_wr(sel_wr), .sel_dirty(sel_dirty),
        .asid_cmp(asid_cmp), .region(nxt_region), .exc(nxt_exc), .paddr(nxt_paddr)
    );

    // Response register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_paddr  <= '0;
            rsp_region <= '0;
            rsp_exc    <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_paddr  <= nxt_paddr;
                rsp_region <= nxt_region;
                rsp_exc    <= nxt_exc;
            end
        end
    end
endmodule

// File: rtl/vat_unit_chk.sv
module vat_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_va,
    input logic [1:0]  req_kind,
    input logic        req_priv,
    input logic        ctl_xlate_en,
    input logic        ctl_sq_lock,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic [1:0]  rsp_region,
    input logic [3:0]  rsp_exc
);
    p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_ctrl_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv && req_va >= 32'hE000_0000)
        |=> (rsp_region == 2'd1 && rsp_exc == 4'd0 && rsp_paddr == $past(req_va)));

    p_ext_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv && req_va[31:30] == 2'b10)
        |=> (rsp_region == 2'd0 && rsp_exc == 4'd0 && rsp_paddr == {3'b000, $past(req_va[28:0])}));

    p_user_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_priv && req_va[31] && !(req_va[31:26] == 6'b111000 && !ctl_sq_lock))
        |=> (rsp_exc == 4'd1 || rsp_exc == 4'd2));

    p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ctl_xlate_en && !req_va[31])
        |=> (rsp_region == 2'd0 && rsp_paddr == {3'b000, $past(req_va[28:0])}));

    p_exc_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc != 4'd0) |-> rsp_region == 2'd3);

    p_ext_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_region == 2'd0) |-> rsp_paddr[31:29] == 3'b000);

    p_pref_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2)
        |=> (rsp_exc == 4'd0 || rsp_exc == 4'd1 || rsp_exc == 4'd5));
endmodule

bind vat_unit vat_unit_chk u_chk (.*);

// File: tb/tb_vat_unit.sv
module tb_vat_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [1:0]  req_kind = '0;
    logic        req_priv = 1'b0;
    logic        ctl_xlate_en = 1'b0;
    logic        ctl_single_vs = 1'b0;
    logic        ctl_sq_lock = 1'b0;
    logic [7:0]  cur_asid = '0;
    logic        tlb_we = 1'b0;
    logic [5:0]  tlb_idx = '0;
    logic [21:0] tlb_vpn = '0;
    logic [7:0]  tlb_asid = '0;
    logic [18:0] tlb_ppn = '0;
    logic [1:0]  tlb_size = '0;
    logic        tlb_valid = 1'b0, tlb_user = 1'b0, tlb_wr = 1'b0, tlb_dirty = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_region;
    logic [3:0]  rsp_exc;

    int n_chk = 0;
    int n_err = 0;
    bit started = 1'b0;
    bit exp_v = 1'b0;

    // Reference TLB contents, filled from the stimulus
    bit          m_v [64], m_u [64], m_w [64], m_d [64];
    int          m_sz [64];
    logic [31:0] m_vb [64], m_pb [64];
    logic [7:0]  m_as [64];

    vat_unit dut (.*);

    always #4 clk = ~clk;

    always @(posedge clk) begin
        exp_v   <= rst_n && req_valid;
        started <= 1'b1;
    end

    // R1: valid tracks the request of the previous edge, every clock
    always @(negedge clk) begin
        if (started) begin
            n_chk++;
            if (rsp_valid !== exp_v) begin
                n_err++;
                $display("FAIL R1: rsp_valid %0b expected %0b", rsp_valid, exp_v);
            end
        end
    end

    function automatic int page_shift(int sz);
        case (sz)
            0: return 10;
            1: return 12;
            2: return 16;
            default: return 20;
        endcase
    endfunction

    function automatic logic [37:0] model(logic [31:0] va, int kind, bit priv,
                                          bit xen, bit svm, bit sql, logic [7:0] ca);
        bit wr;
        bit pf;
        bit ok;
        int hits;
        int sel;
        logic [31:0] off;
        logic [31:0] pa;
        wr = (kind == 1);
        pf = (kind == 2);
        hits = 0;
        sel = 0;
        if (va[31]) begin
            if (priv) begin
                if (va >= 32'hE000_0000) return {2'd1, 4'd0, va};
                if (va < 32'hC000_0000) return {2'd0, 4'd0, va & 32'h1FFF_FFFF};
            end else begin
                if (va >= 32'hE000_0000 && va < 32'hE400_0000 && !sql) return {2'd2, 4'd0, va};
                return {2'd3, (wr ? 4'd2 : 4'd1), va};
            end
        end
        if (!xen) return {2'd0, 4'd0, va & 32'h1FFF_FFFF};
        for (int i = 0; i < 64; i++) begin
            off = (32'd1 << page_shift(m_sz[i])) - 32'd1;
            if (m_v[i] && ((va & ~off) == (m_vb[i] & ~off)) && ((svm && priv) || m_as[i] == ca)) begin
                hits++;
                sel = i;
            end
        end
        if (hits > 1) return {2'd3, 4'd5, va};
        if (hits == 0) return pf ? {2'd3, 4'd0, va} : {2'd3, (wr ? 4'd4 : 4'd3), va};
        if (wr) begin
            ok = priv ? m_w[sel] : (m_u[sel] && m_w[sel]);
            if (!ok) return {2'd3, 4'd7, va};
            if (!m_d[sel]) return {2'd3, 4'd8, va};
        end else if (!priv && !m_u[sel]) begin
            return pf ? {2'd3, 4'd0, va} : {2'd3, 4'd6, va};
        end
        off = (32'd1 << page_shift(m_sz[sel])) - 32'd1;
        pa = (m_pb[sel] & ~off) | (va & off);
        if (pa > 32'h1C00_0000) return {2'd1, 4'd0, pa | 32'hE000_0000};
        return {2'd0, 4'd0, pa};
    endfunction

    task automatic tlb_load(int idx, logic [31:0] vbase, logic [7:0] asid, logic [31:0] pbase,
                            int sz, bit v, bit u, bit w, bit d);
        tlb_idx   = idx[5:0];
        tlb_vpn   = vbase[31:10];
        tlb_asid  = asid;
        tlb_ppn   = pbase[28:10];
        tlb_size  = sz[1:0];
        tlb_valid = v; tlb_user = u; tlb_wr = w; tlb_dirty = d;
        tlb_we    = 1'b1;
        @(negedge clk);
        tlb_we    = 1'b0;
        m_v[idx] = v; m_u[idx] = u; m_w[idx] = w; m_d[idx] = d;
        m_sz[idx] = sz;
        m_vb[idx] = vbase & 32'hFFFF_FC00;
        m_pb[idx] = pbase & 32'h1FFF_FC00;
        m_as[idx] = asid;
    endtask

    task automatic set_ctl(bit xen, bit svm, bit sql, logic [7:0] asid);
        ctl_xlate_en = xen; ctl_single_vs = svm; ctl_sq_lock = sql; cur_asid = asid;
    endtask

    task automatic chk_req(string tag, logic [31:0] va, int kind, bit priv,
                           logic [1:0] er, logic [3:0] ee, logic [31:0] ep);
        req_va = va; req_kind = kind[1:0]; req_priv = priv; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n_chk++;
        if (rsp_region !== er || rsp_exc !== ee || rsp_paddr !== ep) begin
            n_err++;
            $display("FAIL %s: va %h region %0d exp %0d, exc %0d exp %0d, paddr %h exp %h",
                     tag, va, rsp_region, er, rsp_exc, ee, rsp_paddr, ep);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_v[i] = 0; m_u[i] = 0; m_w[i] = 0; m_d[i] = 0;
            m_sz[i] = 0; m_vb[i] = '0; m_pb[i] = '0; m_as[i] = '0;
        end
        repeat (3) @(negedge clk);
        n_chk++;
        if (rsp_valid !== 1'b0 || rsp_region !== 2'd0 || rsp_exc !== 4'd0) begin
            n_err++;
            $display("FAIL R1: reset state valid %0b region %0d exc %0d expected 0 0 0",
                     rsp_valid, rsp_region, rsp_exc);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // TLB contents
        tlb_load(0, 32'h0040_0000, 8'd5, 32'h0080_0000, 1, 1, 1, 1, 1);
        tlb_load(1, 32'h1000_0000, 8'd5, 32'h0123_0000, 2, 1, 0, 1, 0);
        tlb_load(2, 32'h2000_0000, 8'd5, 32'h1C10_0000, 3, 1, 1, 1, 1);
        tlb_load(3, 32'h3000_0400, 8'd5, 32'h1C00_0000, 0, 1, 1, 1, 1);
        tlb_load(4, 32'h4000_0000, 8'd5, 32'h0020_0000, 1, 1, 1, 1, 1);
        tlb_load(5, 32'h4000_0000, 8'd5, 32'h0030_0000, 1, 1, 1, 1, 1);
        tlb_load(6, 32'h5000_0000, 8'd9, 32'h0060_0000, 1, 1, 1, 1, 1);
        tlb_load(7, 32'h6000_0000, 8'd5, 32'h0070_0000, 1, 0, 1, 1, 1);
        tlb_load(8, 32'h0050_0000, 8'd5, 32'h0090_0000, 1, 1, 1, 0, 1);

        set_ctl(1, 0, 0, 8'd5);
        chk_req("R2", 32'hF000_1234, 0, 1, 2'd1, 4'd0, 32'hF000_1234);
        chk_req("R3", 32'hA123_4567, 1, 1, 2'd0, 4'd0, 32'h0123_4567);
        chk_req("R4", 32'hE000_0010, 0, 0, 2'd2, 4'd0, 32'hE000_0010);
        chk_req("R4", 32'hE3FF_FFFC, 1, 0, 2'd2, 4'd0, 32'hE3FF_FFFC);
        chk_req("R4", 32'h9000_0000, 1, 0, 2'd3, 4'd2, 32'h9000_0000);
        chk_req("R4", 32'hC000_0000, 2, 0, 2'd3, 4'd1, 32'hC000_0000);
        chk_req("R4", 32'hE400_0000, 0, 0, 2'd3, 4'd1, 32'hE400_0000);
        set_ctl(1, 0, 1, 8'd5);
        chk_req("R4", 32'hE000_0010, 0, 0, 2'd3, 4'd1, 32'hE000_0010);
        set_ctl(0, 0, 0, 8'd5);
        chk_req("R5", 32'h1234_5678, 0, 0, 2'd0, 4'd0, 32'h1234_5678);
        chk_req("R5", 32'hC000_1000, 0, 1, 2'd0, 4'd0, 32'h0000_1000);
        set_ctl(1, 0, 0, 8'd5);
        chk_req("R5", 32'hC000_1000, 0, 1, 2'd3, 4'd3, 32'hC000_1000);
        chk_req("R11", 32'h0040_0ABC, 0, 0, 2'd0, 4'd0, 32'h0080_0ABC);
        chk_req("R11", 32'h1000_BEEF, 0, 1, 2'd0, 4'd0, 32'h0123_BEEF);
        chk_req("R12", 32'h2001_2345, 0, 0, 2'd1, 4'd0, 32'hFC11_2345);
        chk_req("R12", 32'h3000_0400, 0, 1, 2'd0, 4'd0, 32'h1C00_0000);
        chk_req("R12", 32'h3000_07FF, 0, 1, 2'd1, 4'd0, 32'hFC00_03FF);
        chk_req("R6", 32'h5000_0010, 0, 1, 2'd3, 4'd3, 32'h5000_0010);
        set_ctl(1, 1, 0, 8'd5);
        chk_req("R6", 32'h5000_0010, 0, 1, 2'd0, 4'd0, 32'h0060_0010);
        chk_req("R6", 32'h5000_0010, 0, 0, 2'd3, 4'd3, 32'h5000_0010);
        set_ctl(1, 0, 0, 8'd9);
        chk_req("R6", 32'h5000_0010, 0, 0, 2'd0, 4'd0, 32'h0060_0010);
        set_ctl(1, 0, 0, 8'd5);
        chk_req("R7", 32'h7000_0000, 1, 0, 2'd3, 4'd4, 32'h7000_0000);
        chk_req("R7", 32'h7000_0000, 0, 1, 2'd3, 4'd3, 32'h7000_0000);
        chk_req("R7", 32'h4000_0004, 0, 1, 2'd3, 4'd5, 32'h4000_0004);
        chk_req("R7", 32'h4000_0004, 2, 0, 2'd3, 4'd5, 32'h4000_0004);
        chk_req("R8", 32'h1000_BEEF, 0, 0, 2'd3, 4'd6, 32'h1000_BEEF);
        chk_req("R13", 32'h1000_BEEF, 2, 0, 2'd3, 4'd0, 32'h1000_BEEF);
        chk_req("R13", 32'h7000_0000, 2, 1, 2'd3, 4'd0, 32'h7000_0000);
        chk_req("R13", 32'h0040_0ABC, 2, 0, 2'd0, 4'd0, 32'h0080_0ABC);
        chk_req("R9", 32'h1000_BEEF, 1, 0, 2'd3, 4'd7, 32'h1000_BEEF);
        chk_req("R10", 32'h1000_BEEF, 1, 1, 2'd3, 4'd8, 32'h1000_BEEF);
        chk_req("R9", 32'h0050_0010, 1, 0, 2'd3, 4'd7, 32'h0050_0010);
        chk_req("R9", 32'h0050_0010, 1, 1, 2'd3, 4'd7, 32'h0050_0010);
        chk_req("R9", 32'h0040_0ABC, 1, 0, 2'd0, 4'd0, 32'h0080_0ABC);
        chk_req("R14", 32'h6000_0123, 0, 1, 2'd3, 4'd3, 32'h6000_0123);
        tlb_load(7, 32'h6000_0000, 8'd5, 32'h0070_0000, 1, 1, 1, 1, 1);
        chk_req("R14", 32'h6000_0123, 0, 1, 2'd0, 4'd0, 32'h0070_0123);

        // Mixed requests against the reference model
        for (int n = 0; n < 600; n++) begin
            logic [31:0] base;
            logic [37:0] e;
            int          kind;
            bit          priv;
            case ($urandom % 14)
                0:  base = 32'h0040_0000;
                1:  base = 32'h1000_0000;
                2:  base = 32'h2000_0000;
                3:  base = 32'h3000_0000;
                4:  base = 32'h4000_0000;
                5:  base = 32'h5000_0000;
                6:  base = 32'h6000_0000;
                7:  base = 32'h7000_0000;
                8:  base = 32'h0050_0000;
                9:  base = 32'hC000_0000;
                10: base = 32'hE000_0000;
                11: base = 32'hA000_0000;
                12: base = 32'hF000_0000;
                default: base = 32'h9000_0000;
            endcase
            base = base | ($urandom & 32'h0000_0FFF);
            kind = $urandom % 3;
            priv = $urandom % 2;
            set_ctl(($urandom % 4) != 0, $urandom % 2, $urandom % 2, (($urandom % 2) != 0) ? 8'd5 : 8'd9);
            e = model(base, kind, priv, ctl_xlate_en, ctl_single_vs, ctl_sq_lock, cur_asid);
            chk_req("R11", base, kind, priv, e[37:36], e[35:32], e[31:0]);
            if (($urandom % 4) == 0) @(negedge clk);
        end

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule